// File: doc/BRIEF.md
# Wake Event Aggregator with Scan-Code Match

This block collects wake events from general-purpose inputs, fan tachometer pulses and a keyboard byte stream, and turns them into one active-low wake request. Each source has a sticky status bit and its own enable bit. A single global enable decides whether any pending enabled status may drive the request low. Status bits record events whether or not the global enable is set, so software can poll them with the request disabled.

Each general-purpose input passes through a two-flop synchronizer and an edge detector. The detector fires on the rising edge, on the falling edge when its polarity bit is set, or on both edges when its dual-edge bit is set. Tachometer inputs use the same detector, fixed to rising edges. Keyboard bytes arrive with a valid strobe. A byte equal to the programmed wake scan code sets the key status bit. The scan-code register sits in the standby reset domain, so a main reset leaves it unchanged.

The request output comes from a two-state machine. In W_IDLE the output is high. The transition "raise" moves it to W_ASSERT when the global enable is set and at least one source has both status and enable set. In W_ASSERT the output is low. The transition "release" returns it to W_IDLE as soon as that condition drops. Software reaches the block through a simple register port: an 8-bit address, a write strobe, and a read strobe whose data appears one cycle later.

Top module: `wake_evt_ctrl`

## Requirements
- R1: After main reset, every status bit, every enable bit, the polarity and dual-edge bits and the global enable are 0, and wake_n is 1.
- R2: wake_n is driven low only in a cycle that follows a cycle in which the global enable (address 0x04 bit 0) was 1.
- R3: With the global enable set, wake_n goes low one cycle after any source has both its status bit and its enable bit at 1, and it returns high one cycle after no such source remains.
- R4: A source event sets its status bit whether or not the global enable is set, and a status bit stays set until software clears it.
- R5: Writing 1 to a status bit (address 0x00 for the general-purpose inputs, 0x01 for the others) clears it. Writing 0 leaves it unchanged.
- R6: For general-purpose input i with polarity bit i (address 0x05) at 0, a rising edge sets status bit i of address 0x00. With the polarity bit at 1, only a falling edge sets it.
- R7: With dual-edge bit i (address 0x06) set, both rising and falling edges of input i set its status bit.
- R8: A rising edge on tachometer input j sets bit j of status address 0x01, and bit j of enable address 0x03 enables it as a wake source.
- R9: A byte with kb_valid=1 that equals the scan-code register (address 0x11) sets bit 5 of status address 0x01, enabled by bit 5 of address 0x03. A mismatched byte, or a matching byte without kb_valid, has no effect.
- R10: The scan-code register resets to 0x00 only on sb_rst_n. A main reset (rst_n) keeps its value.
- R11: A single input transition sets status only once. After that status is cleared, a steady input level does not set it again.
- R12: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R13: reg_rdata presents the addressed register one cycle after reg_rd. Enables are at 0x02/0x03, and only the implemented bits read back as written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Main-power reset, active low |
| sb_rst_n | input | 1 | Standby-power reset, active low, resets the scan-code register |
| gpio_in | input | NUM_GPIO | General-purpose wake inputs, asynchronous |
| tach_in | input | NUM_FAN | Fan tachometer pulse inputs, asynchronous |
| kb_valid | input | 1 | Keyboard byte strobe |
| kb_code | input | 8 | Keyboard scan-code byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid one cycle after reg_rd |
| wake_n | output | 1 | Wake request, active low |

## Verification
The bench latches events with the global enable off and checks that the request stays high. A design that gates status capture with the global enable would lose those events. It checks that a falling edge is ignored under default polarity, that a selected falling edge is caught, and that dual-edge mode catches both edges. A swapped or missing polarity or dual-edge term shows up here. It clears a status bit while the input is still held high, which catches a level-sensitive detector that sets the bit again. It lands a scan-code match on the same cycle as a clear of that bit, which catches a clear-wins priority. Finally, it pulses the main reset and the standby reset separately: a scan code lost on main reset, or kept through standby reset, fails those reads.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_STS0 = 8'h00;
    localparam logic [ADDR_W-1:0] A_STS1 = 8'h01;
    localparam logic [ADDR_W-1:0] A_EN0  = 8'h02;
    localparam logic [ADDR_W-1:0] A_EN1  = 8'h03;
    localparam logic [ADDR_W-1:0] A_GLOB = 8'h04;
    localparam logic [ADDR_W-1:0] A_POL  = 8'h05;
    localparam logic [ADDR_W-1:0] A_DUAL = 8'h06;
    localparam logic [ADDR_W-1:0] A_KEY  = 8'h11;

    localparam int KEY_BIT = 5;

    typedef enum logic [0:0] {
        W_IDLE   = 1'b0,
        W_ASSERT = 1'b1
    } wake_state_e;
endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic fall_sel,
    input  logic dual_sel,
    output logic evt
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its previous value
    logic [CHAIN_W-1:0] chain;
    logic               rise;
    logic               fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-1:0], din};
    end

    always_comb begin
        rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
        fall = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];
        if (dual_sel)      evt = rise | fall;
        else if (fall_sel) evt = fall;
        else               evt = rise;
    end

    // R11: one transition yields a one-cycle event
    p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
endmodule

// File: rtl/wake_key_match.sv
module wake_key_match #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sb_rst_n,
    input  logic              code_wr,
    input  logic [CODE_W-1:0] code_wdata,
    input  logic              kb_valid,
    input  logic [CODE_W-1:0] kb_code,
    output logic [CODE_W-1:0] scan_code,
    output logic              hit
);
    // scan code lives in the standby domain
    always_ff @(posedge clk or negedge sb_rst_n) begin
        if (!sb_rst_n)    scan_code <= '0;
        else if (code_wr) scan_code <= code_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= kb_valid && (kb_code == scan_code);
    end

    // R9: a hit always follows a strobed byte
    p_hit_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(kb_valid));
endmodule

// File: rtl/wake_out_fsm.sv
module wake_out_fsm
    import wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic glob_en,
    input  logic pending,
    output logic wake_n
);
    wake_state_e state_q;
    wake_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:   if (glob_en && pending)    state_d = W_ASSERT; // raise
            W_ASSERT: if (!(glob_en && pending)) state_d = W_IDLE;   // release
        endcase
    end

    always_comb begin
        unique case (state_q)
            W_IDLE:   wake_n = 1'b1;
            W_ASSERT: wake_n = 1'b0;
        endcase
    end

    p_gated_by_global_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_n |-> $past(glob_en));

    p_raise_on_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && pending) |=> !wake_n);

    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(glob_en && pending) |=> wake_n);
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
    import wake_pkg::*;
#(
    parameter int NUM_GPIO    = 4,
    parameter int NUM_FAN     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sb_rst_n,
    input  logic [NUM_GPIO-1:0] gpio_in,
    input  logic [NUM_FAN-1:0]  tach_in,
    input  logic                kb_valid,
    input  logic [7:0]          kb_code,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [7:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    output logic                wake_n
);
    logic [NUM_GPIO-1:0] gpio_evt;
    logic [NUM_FAN-1:0]  fan_evt;
    logic                key_hit;
    logic [7:0]          scan_code;

    logic [NUM_GPIO-1:0] sts_gpio, en_gpio, pol_gpio, dual_gpio;
    logic [NUM_FAN-1:0]  sts_fan, en_fan;
    logic                sts_key, en_key, glob_en;

    logic                wr_sts0, wr_sts1, wr_en0, wr_en1, wr_glob, wr_pol, wr_dual, wr_key;
    logic [NUM_GPIO-1:0] clr_gpio;
    logic [NUM_FAN-1:0]  clr_fan;
    logic                clr_key;
    logic                pending;
    logic [7:0]          rd_mux;

    // event sources
    for (genvar g = 0; g < NUM_GPIO; g++) begin : g_gpio
        wake_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .din      (gpio_in[g]),
            .fall_sel (pol_gpio[g]),
            .dual_sel (dual_gpio[g]),
            .evt      (gpio_evt[g])
        );
    end

    for (genvar f = 0; f < NUM_FAN; f++) begin : g_fan
        wake_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .din      (tach_in[f]),
            .fall_sel (1'b0),
            .dual_sel (1'b0),
            .evt      (fan_evt[f])
        );
    end

    wake_key_match #(.CODE_W(8)) key_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sb_rst_n   (sb_rst_n),
        .code_wr    (wr_key),
        .code_wdata (reg_wdata),
        .kb_valid   (kb_valid),
        .kb_code    (kb_code),
        .scan_code  (scan_code),
        .hit        (key_hit)
    );

    // write decode
    always_comb begin
        wr_sts0 = reg_wr && (reg_addr == A_STS0);
        wr_sts1 = reg_wr && (reg_addr == A_STS1);
        wr_en0  = reg_wr && (reg_addr == A_EN0);
        wr_en1  = reg_wr && (reg_addr == A_EN1);
        wr_glob = reg_wr && (reg_addr == A_GLOB);
        wr_pol  = reg_wr && (reg_addr == A_POL);
        wr_dual = reg_wr && (reg_addr == A_DUAL);
        wr_key  = reg_wr && (reg_addr == A_KEY);
        clr_gpio = wr_sts0 ? reg_wdata[NUM_GPIO-1:0] : '0;
        clr_fan  = wr_sts1 ? reg_wdata[NUM_FAN-1:0]  : '0;
        clr_key  = wr_sts1 & reg_wdata[KEY_BIT];
    end

    // sticky status, set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_gpio <= '0;
            sts_fan  <= '0;
            sts_key  <= 1'b0;
        end else begin
            sts_gpio <= (sts_gpio & ~clr_gpio) | gpio_evt;
            sts_fan  <= (sts_fan & ~clr_fan) | fan_evt;
            sts_key  <= (sts_key & ~clr_key) | key_hit;
        end
    end

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_gpio   <= '0;
            en_fan    <= '0;
            en_key    <= 1'b0;
            glob_en   <= 1'b0;
            pol_gpio  <= '0;
            dual_gpio <= '0;
        end else begin
            if (wr_en0)  en_gpio   <= reg_wdata[NUM_GPIO-1:0];
            if (wr_en1) begin
                en_fan <= reg_wdata[NUM_FAN-1:0];
                en_key <= reg_wdata[KEY_BIT];
            end
            if (wr_glob) glob_en   <= reg_wdata[0];
            if (wr_pol)  pol_gpio  <= reg_wdata[NUM_GPIO-1:0];
            if (wr_dual) dual_gpio <= reg_wdata[NUM_GPIO-1:0];
        end
    end

    // read mux
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            A_STS0: rd_mux[NUM_GPIO-1:0] = sts_gpio;
            A_STS1: begin
                rd_mux[NUM_FAN-1:0] = sts_fan;
                rd_mux[KEY_BIT]     = sts_key;
            end
            A_EN0:  rd_mux[NUM_GPIO-1:0] = en_gpio;
            A_EN1: begin
                rd_mux[NUM_FAN-1:0] = en_fan;
                rd_mux[KEY_BIT]     = en_key;
            end
            A_GLOB: rd_mux[0] = glob_en;
            A_POL:  rd_mux[NUM_GPIO-1:0] = pol_gpio;
            A_DUAL: rd_mux[NUM_GPIO-1:0] = dual_gpio;
            A_KEY:  rd_mux = scan_code;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    always_comb begin
        pending = (|(sts_gpio & en_gpio)) | (|(sts_fan & en_fan)) | (sts_key & en_key);
    end

    wake_out_fsm out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .glob_en (glob_en),
        .pending (pending),
        .wake_n  (wake_n)
    );

    // R4: status bits are sticky without a clear
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sts0 |=> ((sts_gpio & $past(sts_gpio)) == $past(sts_gpio)));

    // R12: an event always lands, even against a clear
    for (genvar g = 0; g < NUM_GPIO; g++) begin : g_chk
        p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
            gpio_evt[g] |=> sts_gpio[g]);
    end

    p_key_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit |=> sts_key);
endmodule

// File: tb/wake_evt_ctrl_tb.sv
module wake_evt_ctrl_tb_top;
    localparam int NG = 4;
    localparam int NF = 2;
    localparam int NV = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sb_rst_n = 1'b0;
    logic [NG-1:0] gpio_in = '0;
    logic [NF-1:0] tach_in = '0;
    logic          kb_valid = 1'b0;
    logic [7:0]    kb_code = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          wake_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wake_evt_ctrl #(.NUM_GPIO(NG), .NUM_FAN(NF)) dut_i (
        .clk(clk), .rst_n(rst_n), .sb_rst_n(sb_rst_n), .gpio_in(gpio_in),
        .tach_in(tach_in), .kb_valid(kb_valid), .kb_code(kb_code),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_n(wake_n)
    );

    // {op, addr, data}: op 1 = write, 2 = read and compare (R13)
    localparam logic [17:0] VECS [NV] = '{
        {2'd1, 8'h02, 8'h0A}, {2'd2, 8'h02, 8'h0A},
        {2'd1, 8'h03, 8'h23}, {2'd2, 8'h03, 8'h23},
        {2'd1, 8'h05, 8'h05}, {2'd2, 8'h05, 8'h05},
        {2'd1, 8'h06, 8'h0C}, {2'd2, 8'h06, 8'h0C},
        {2'd1, 8'h04, 8'h01}, {2'd2, 8'h04, 8'h01},
        {2'd1, 8'h11, 8'h5A}, {2'd2, 8'h11, 8'h5A},
        {2'd2, 8'h07, 8'h00}, {2'd2, 8'h20, 8'h00},
        {2'd1, 8'h02, 8'hFF}, {2'd2, 8'h02, 8'h0F},
        {2'd1, 8'h03, 8'hFF}, {2'd2, 8'h03, 8'h23}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic kb_send(input logic [7:0] c, input logic v);
        kb_valid = v; kb_code = c;
        @(negedge clk);
        kb_valid = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        idle(3);
        sb_rst_n = 1'b1; rst_n = 1'b1;
        idle(2);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][17:16] == 2'd1) wr(VECS[i][15:8], VECS[i][7:0]);
            else begin
                rd(VECS[i][15:8], v);
                chk($sformatf("R13 vector %0d", i), v, VECS[i][7:0]);
            end
        end

        // main reset: everything clears except scan code
        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(2);
        chk("R1 wake_n", {7'd0, wake_n}, 8'h01);
        rd(8'h02, v); chk("R1 enable0", v, 8'h00);
        rd(8'h03, v); chk("R1 enable1", v, 8'h00);
        rd(8'h04, v); chk("R1 global", v, 8'h00);
        rd(8'h05, v); chk("R1 polarity", v, 8'h00);
        rd(8'h00, v); chk("R1 status0", v, 8'h00);
        rd(8'h11, v); chk("R10 scan kept on main reset", v, 8'h5A);
        sb_rst_n = 1'b0; idle(1); sb_rst_n = 1'b1; idle(1);
        rd(8'h11, v); chk("R10 scan cleared on standby reset", v, 8'h00);

        // R4 / R2: capture with global off
        wr(8'h02, 8'h01);
        gpio_in[0] = 1'b1; idle(5);
        rd(8'h00, v); chk("R4 status with global off", v, 8'h01);
        chk("R2 wake_n high with global off", {7'd0, wake_n}, 8'h01);
        wr(8'h04, 8'h01); idle(3);
        chk("R3 wake_n low", {7'd0, wake_n}, 8'h00);
        wr(8'h00, 8'h00); idle(2);
        rd(8'h00, v); chk("R5 write zero keeps status", v, 8'h01);
        wr(8'h00, 8'h01); idle(3);
        rd(8'h00, v); chk("R5 write one clears status", v, 8'h00);
        chk("R3 wake_n released", {7'd0, wake_n}, 8'h01);
        idle(5);
        rd(8'h00, v); chk("R11 held level does not re-set", v, 8'h00);
        gpio_in[0] = 1'b0; idle(5);
        rd(8'h00, v); chk("R6 falling ignored by default", v, 8'h00);

        // R6: falling polarity on input 1
        wr(8'h05, 8'h02);
        gpio_in[1] = 1'b1; idle(5);
        rd(8'h00, v); chk("R6 rising ignored when inverted", v, 8'h00);
        gpio_in[1] = 1'b0; idle(5);
        rd(8'h00, v); chk("R6 falling sets when inverted", v, 8'h02);
        wr(8'h00, 8'h02);

        // R7: dual edge on input 2
        wr(8'h06, 8'h04);
        gpio_in[2] = 1'b1; idle(5);
        rd(8'h00, v); chk("R7 rising in dual mode", v, 8'h04);
        wr(8'h00, 8'h04); idle(2);
        gpio_in[2] = 1'b0; idle(5);
        rd(8'h00, v); chk("R7 falling in dual mode", v, 8'h04);
        wr(8'h00, 8'h04);

        // R8: tachometer 1
        wr(8'h03, 8'h02);
        tach_in[1] = 1'b1; idle(2); tach_in[1] = 1'b0; idle(5);
        rd(8'h01, v); chk("R8 tach status", v, 8'h02);
        chk("R8 tach wakes", {7'd0, wake_n}, 8'h00);
        wr(8'h01, 8'h02); idle(3);
        chk("R8 tach cleared releases", {7'd0, wake_n}, 8'h01);

        // R9: scan-code match
        wr(8'h11, 8'h3C);
        kb_send(8'h11, 1'b1); idle(3);
        rd(8'h01, v); chk("R9 mismatch ignored", v, 8'h00);
        kb_send(8'h3C, 1'b0); idle(3);
        rd(8'h01, v); chk("R9 no strobe ignored", v, 8'h00);
        chk("R9 wake_n high without key", {7'd0, wake_n}, 8'h01);
        wr(8'h03, 8'h20);
        kb_send(8'h3C, 1'b1); idle(3);
        rd(8'h01, v); chk("R9 match sets bit 5", v, 8'h20);
        chk("R9 key wakes", {7'd0, wake_n}, 8'h00);

        // R12: new hit lands in the clear cycle
        kb_valid = 1'b1; kb_code = 8'h3C;
        @(negedge clk);
        kb_valid = 1'b0;
        wr(8'h01, 8'h20);
        rd(8'h01, v); chk("R12 set wins over clear", v, 8'h20);
        wr(8'h01, 8'h20);
        rd(8'h01, v); chk("R5 key status cleared", v, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule